// File: doc/BRIEF.md
# Two-Thread Idle State Coordinator

This block keeps the idle state of each hardware thread of a core and derives one core idle state from them. A thread asks to go idle in one of two ways. It can use the direct wait port, which carries a target state, a sub-state hint and a flag that arms the address monitor. It can also issue a legacy I/O read to a level address. When redirection is enabled and the read lands inside a programmed capture window, the read is turned into an equivalent wait request.

A thread that is idle returns to the running state when an interrupt reaches it. If it armed the monitor, a write to the monitored address also wakes it. Each thread wakes on its own. The core state is always the shallowest state held by any thread. I/O reads that are not captured pass through as ordinary reads, and the block raises a fall-through flag for them.

Top module: `idle_coord`

## Requirements
- R1: States are encoded C0=0, C1=1, C1E=2, C3=3, C6=4. `core_cstate` always equals the numerically lowest thread state, and it follows a change of a thread state in the same cycle that the thread state changes.
- R2: A direct request with `req_vld` high goes to thread `req_tid`. If that thread is in C0 and `req_cstate` is 1 to 4, the thread takes that state one clock later, and it records `req_sub` on `thr_sub` and `req_mon` as its armed flag. A target of 0 or of 5 to 7 is ignored.
- R3: A request, whether direct or converted, that targets a thread not in C0 is ignored. The thread's state and sub-state stay unchanged.
- R4: An idle thread whose `intr_en` bit is set returns to C0 one clock after its `irq` bit is high. The other thread is not affected, so the core goes to C0.
- R5: An idle thread whose `intr_en` bit is clear and that has no break-on-interrupt attribute ignores its `irq` bit.
- R6: A `mon_hit` pulse returns to C0 every idle thread that armed the monitor. Idle threads that did not arm it stay where they are.
- R7: A captured read is converted when `mon_addr_vld` is high and the thread is in C0. A read at `lvl_base` (level 2) becomes C3, and a read at `lvl_base+1` (level 3) becomes C6. The converted request sets sub-state 0, arms the monitor and sets break-on-interrupt.
- R8: A thread that went idle through a converted read wakes on its `irq` bit even when its `intr_en` bit is clear.
- R9: A read is captured only when `redir_en` is high, `io_addr` lies in the window [`cap_lo`, `cap_hi`] inclusive, and `io_addr` is one of the two level addresses. Any other read asserts `io_fallthru` in the same cycle and leaves the thread state unchanged.
- R10: A captured read while `mon_addr_vld` is low does not assert `io_fallthru` and changes no thread state.
- R11: While `rst_n` is low, every thread state, every sub-state and the core state are C0 / 0.
- R12: If a direct request and a captured read target the same thread in the same cycle, the direct request wins. The read is consumed without fall-through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| redir_en | input | 1 | Enables conversion of legacy reads |
| mon_addr_vld | input | 1 | Monitor address has been programmed |
| cap_lo | input | AW | Lowest captured I/O address |
| cap_hi | input | AW | Highest captured I/O address |
| lvl_base | input | AW | Level-2 address; level-3 is the next address |
| req_vld | input | 1 | Direct wait request strobe |
| req_tid | input | TW | Target thread of the direct request |
| req_cstate | input | 3 | Requested idle state |
| req_sub | input | SW | Sub-state hint |
| req_mon | input | 1 | Arm the address monitor |
| io_vld | input | 1 | Legacy I/O read strobe |
| io_tid | input | TW | Thread issuing the read |
| io_addr | input | AW | Read address |
| irq | input | NT | Per-thread interrupt |
| intr_en | input | NT | Per-thread interrupt-enable flag |
| mon_hit | input | 1 | Write hit the monitored address |
| thr_cstate | output | 3*NT | Per-thread state, thread t at bits [3t+2:3t] |
| thr_sub | output | SW*NT | Per-thread sub-state |
| core_cstate | output | 3 | Resolved core state |
| io_fallthru | output | 1 | Read was not captured and passes through |

## Verification
The assertions check the per-cycle rules on every cycle: the core state never exceeds any thread state, enabled interrupts and monitor hits on armed threads wake the thread on the next cycle, idle threads without a wake event hold their state, fall-through reads leave a running thread running, and converted reads land in C3 or C6 with sub-state zero. Some behaviours show only over a sequence, so the bench scenarios cover them. These are the level-address mapping, the masked-interrupt override of converted reads, the unarmed thread ignoring the monitor, the ignored request while the monitor address is invalid, and the winner when both request paths collide.

// File: rtl/idle_coord.sv
module idle_coord #(
  parameter int NT = 2,
  parameter int AW = 16,
  parameter int SW = 4,
  localparam int TW = (NT > 1) ? $clog2(NT) : 1,
  localparam int CW = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             redir_en,
  input  logic             mon_addr_vld,
  input  logic [AW-1:0]    cap_lo,
  input  logic [AW-1:0]    cap_hi,
  input  logic [AW-1:0]    lvl_base,
  input  logic             req_vld,
  input  logic [TW-1:0]    req_tid,
  input  logic [CW-1:0]    req_cstate,
  input  logic [SW-1:0]    req_sub,
  input  logic             req_mon,
  input  logic             io_vld,
  input  logic [TW-1:0]    io_tid,
  input  logic [AW-1:0]    io_addr,
  input  logic [NT-1:0]    irq,
  input  logic [NT-1:0]    intr_en,
  input  logic             mon_hit,
  output logic [NT*CW-1:0] thr_cstate,
  output logic [NT*SW-1:0] thr_sub,
  output logic [CW-1:0]    core_cstate,
  output logic             io_fallthru
);

  localparam logic [CW-1:0] C0 = 3'd0;
  localparam logic [CW-1:0] C1 = 3'd1;
  localparam logic [CW-1:0] C3 = 3'd3;
  localparam logic [CW-1:0] C6 = 3'd4;

  logic [CW-1:0] st  [NT];
  logic [SW-1:0] sub [NT];
  logic [NT-1:0] armed, brk;

  wire lvl2_hit = io_addr == lvl_base;
  wire lvl3_hit = io_addr == lvl_base + AW'(1);
  wire in_win   = (io_addr >= cap_lo) && (io_addr <= cap_hi);
  wire captured = io_vld && redir_en && in_win && (lvl2_hit || lvl3_hit);
  wire cnv_go   = captured && mon_addr_vld;
  wire [CW-1:0] cnv_state = lvl3_hit ? C6 : C3;
  wire req_ok   = req_vld && (req_cstate >= C1) && (req_cstate <= C6);

  assign io_fallthru = io_vld && !captured;

  always_comb begin
    core_cstate = st[0];
    for (int i = 1; i < NT; i++)
      if (st[i] < core_cstate) core_cstate = st[i];
  end

  for (genvar t = 0; t < NT; t++) begin : g_thr
    wire dsel = req_vld && (req_tid == TW'(t));
    wire dreq = req_ok && (req_tid == TW'(t));
    wire creq = cnv_go && (io_tid == TW'(t)) && !dsel;
    wire wake = (irq[t] && (intr_en[t] || brk[t])) || (mon_hit && armed[t]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st[t] <= C0; sub[t] <= '0; armed[t] <= 1'b0; brk[t] <= 1'b0;
      end else if (st[t] == C0) begin
        if (dreq) begin
          st[t] <= req_cstate; sub[t] <= req_sub;
          armed[t] <= req_mon; brk[t] <= 1'b0;
        end else if (creq) begin
          st[t] <= cnv_state; sub[t] <= '0;
          armed[t] <= 1'b1; brk[t] <= 1'b1;
        end
      end else if (wake) begin
        st[t] <= C0; sub[t] <= '0; armed[t] <= 1'b0; brk[t] <= 1'b0;
      end
    end

    assign thr_cstate[t*CW +: CW] = st[t];
    assign thr_sub[t*SW +: SW]    = sub[t];

    // R1
    core_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
      core_cstate <= st[t]);
    // R4
    irq_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st[t] != C0 && irq[t] && intr_en[t]) |=> st[t] == C0);
    // R6
    mon_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st[t] != C0 && mon_hit && armed[t]) |=> st[t] == C0);
    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st[t] != C0 && !irq[t] && !mon_hit) |=> ($stable(st[t]) && $stable(sub[t])));
    // R9
    ft_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_fallthru && io_tid == TW'(t) && st[t] == C0 && !dsel) |=> st[t] == C0);
    // R7
    cnv_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st[t] == C0 && io_vld && io_tid == TW'(t) && !io_fallthru && mon_addr_vld && !dsel)
        |=> (sub[t] == '0 && (st[t] == C3 || st[t] == C6)));
  end

endmodule

// File: tb/test_idle_coord.sv
module test_idle_coord;
  localparam int NT = 2, AW = 16, SW = 4, TW = 1;

  logic clk = 0, rst_n = 0;
  logic redir_en, mon_addr_vld, req_vld, req_mon, io_vld, mon_hit;
  logic [AW-1:0] cap_lo, cap_hi, lvl_base, io_addr;
  logic [TW-1:0] req_tid, io_tid;
  logic [2:0] req_cstate;
  logic [SW-1:0] req_sub;
  logic [NT-1:0] irq, intr_en;
  logic [NT*3-1:0] thr_cstate;
  logic [NT*SW-1:0] thr_sub;
  logic [2:0] core_cstate;
  logic io_fallthru;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  idle_coord #(.NT(NT), .AW(AW), .SW(SW)) i_idle_coord (
    .clk, .rst_n, .redir_en, .mon_addr_vld, .cap_lo, .cap_hi, .lvl_base,
    .req_vld, .req_tid, .req_cstate, .req_sub, .req_mon,
    .io_vld, .io_tid, .io_addr, .irq, .intr_en, .mon_hit,
    .thr_cstate, .thr_sub, .core_cstate, .io_fallthru);

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int ts(int t); return int'(thr_cstate[t*3 +: 3]); endfunction
  function automatic int tsub(int t); return int'(thr_sub[t*SW +: SW]); endfunction

  task automatic clear_in();
    req_vld = 0; req_tid = 0; req_cstate = 0; req_sub = 0; req_mon = 0;
    io_vld = 0; io_tid = 0; io_addr = 0; irq = 0; mon_hit = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; clear_in();
    redir_en = 1; mon_addr_vld = 1; intr_en = 2'b11;
    cap_lo = 16'h0400; cap_hi = 16'h04FF; lvl_base = 16'h0414;
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1;
  endtask

  task automatic do_req(int tid, int cs, int sb, bit mon);
    @(negedge clk);
    req_vld = 1; req_tid = TW'(tid); req_cstate = 3'(cs); req_sub = SW'(sb); req_mon = mon;
    @(posedge clk); #1;
    @(negedge clk); req_vld = 0;
  endtask

  task automatic do_io(int tid, int addr, output bit ft);
    @(negedge clk);
    io_vld = 1; io_tid = TW'(tid); io_addr = AW'(addr);
    #1 ft = io_fallthru;
    @(posedge clk); #1;
    @(negedge clk); io_vld = 0;
  endtask

  task automatic do_irq(logic [NT-1:0] v);
    @(negedge clk); irq = v;
    @(posedge clk); #1;
    @(negedge clk); irq = 0;
  endtask

  task automatic do_mon();
    @(negedge clk); mon_hit = 1;
    @(posedge clk); #1;
    @(negedge clk); mon_hit = 0;
  endtask

  task automatic t_reset();
    @(negedge clk); rst_n = 0; clear_in();
    @(posedge clk); #1;
    check("R11 thread0 state in reset", ts(0), 0);
    check("R11 thread1 state in reset", ts(1), 0);
    check("R11 core state in reset", core_cstate, 0);
    check("R11 sub-state in reset", tsub(0), 0);
    do_reset();
  endtask

  task automatic t_direct();
    do_reset();
    do_req(0, 1, 5, 0);
    check("R2 thread0 enters C1", ts(0), 1);
    check("R2 thread0 sub recorded", tsub(0), 5);
    check("R1 core stays C0 while thread1 runs", core_cstate, 0);
    do_req(1, 3, 2, 0);
    check("R1 core is shallowest (C1)", core_cstate, 1);
  endtask

  task automatic t_invalid();
    do_reset();
    do_req(0, 0, 3, 0);
    check("R2 target 0 ignored", ts(0), 0);
    do_req(0, 5, 3, 0);
    check("R2 target 5 ignored", ts(0), 0);
    do_req(0, 7, 3, 0);
    check("R2 target 7 ignored", ts(0), 0);
  endtask

  task automatic t_busy();
    bit ft;
    do_reset();
    do_req(0, 1, 5, 0);
    do_req(0, 4, 7, 1);
    check("R3 busy thread state kept", ts(0), 1);
    check("R3 busy thread sub kept", tsub(0), 5);
    do_io(0, 16'h0415, ft);
    check("R3 converted read to busy thread ignored", ts(0), 1);
  endtask

  task automatic t_irq();
    do_reset();
    do_req(0, 2, 0, 0);
    do_req(1, 3, 0, 0);
    check("R1 core C1E over C3", core_cstate, 2);
    do_irq(2'b10);
    check("R4 woken thread1 to C0", ts(1), 0);
    check("R4 thread0 untouched", ts(0), 2);
    check("R4 core resolves C0", core_cstate, 0);
  endtask

  task automatic t_masked();
    do_reset();
    intr_en = 2'b00;
    do_req(0, 3, 1, 0);
    do_irq(2'b01);
    check("R5 masked irq ignored", ts(0), 3);
    do_mon();
    check("R6 unarmed thread ignores monitor", ts(0), 3);
    intr_en = 2'b11;
  endtask

  task automatic t_monitor();
    do_reset();
    do_req(0, 1, 0, 1);
    do_req(1, 1, 0, 0);
    do_mon();
    check("R6 armed thread0 wakes", ts(0), 0);
    check("R6 unarmed thread1 stays", ts(1), 1);
  endtask

  task automatic t_legacy();
    bit ft;
    do_reset();
    intr_en = 2'b00;
    do_io(0, 16'h0414, ft);
    check("R7 level-2 read captured", int'(ft), 0);
    check("R7 level-2 gives C3", ts(0), 3);
    check("R7 converted sub is zero", tsub(0), 0);
    do_io(1, 16'h0415, ft);
    check("R7 level-3 gives C6", ts(1), 4);
    check("R1 core C3 over C6", core_cstate, 3);
    do_irq(2'b01);
    check("R8 break-on-interrupt wakes masked thread", ts(0), 0);
    do_mon();
    check("R7 converted request arms monitor", ts(1), 0);
    intr_en = 2'b11;
  endtask

  task automatic t_fall();
    bit ft;
    do_reset();
    redir_en = 0;
    do_io(0, 16'h0414, ft);
    check("R9 disabled redirection falls through", int'(ft), 1);
    check("R9 state unchanged when disabled", ts(0), 0);
    redir_en = 1; cap_hi = 16'h0410;
    do_io(0, 16'h0414, ft);
    check("R9 out-of-window read falls through", int'(ft), 1);
    check("R9 state unchanged out of window", ts(0), 0);
    cap_hi = 16'h04FF;
    do_io(1, 16'h0416, ft);
    check("R9 non-level address falls through", int'(ft), 1);
    check("R9 state unchanged on non-level", ts(1), 0);
  endtask

  task automatic t_nomon();
    bit ft;
    do_reset();
    mon_addr_vld = 0;
    do_io(0, 16'h0414, ft);
    check("R10 no fall-through without monitor address", int'(ft), 0);
    check("R10 state unchanged without monitor address", ts(0), 0);
    mon_addr_vld = 1;
  endtask

  task automatic t_conflict();
    do_reset();
    @(negedge clk);
    req_vld = 1; req_tid = 0; req_cstate = 3'd1; req_sub = 4'd9; req_mon = 0;
    io_vld = 1; io_tid = 0; io_addr = 16'h0415;
    #1 check("R12 read consumed without fall-through", int'(io_fallthru), 0);
    @(posedge clk); #1;
    check("R12 direct request wins", ts(0), 1);
    check("R12 direct sub kept", tsub(0), 9);
    @(negedge clk); clear_in();
  endtask

  initial begin
    clear_in();
    redir_en = 1; mon_addr_vld = 1; intr_en = 2'b11;
    cap_lo = 16'h0400; cap_hi = 16'h04FF; lvl_base = 16'h0414;
    t_reset();
    t_direct();
    t_invalid();
    t_busy();
    t_irq();
    t_masked();
    t_monitor();
    t_legacy();
    t_fall();
    t_nomon();
    t_conflict();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule